// File: doc/BRIEF.md
# Local Bus Cycle Command Sequencer

This block runs one processor-style bus operation at a time on a local bus. A start request and a read/write flag begin a cycle. The sequencer then steps through a status state and one or more command states. It drives the address latch strobe, the read and write command strobes, the transceiver enable and the transceiver direction.

Each bus state lasts two clocks, called phase 1 and phase 2. Phase 1 ends at the half-state point, which stands in for a falling-edge sample. Phase 2 ends at the state boundary. The `phase2` output marks the second half of each state.

Two inputs change the timing of a cycle:

- **Command delay.** A hold input keeps the command strobe off. It is sampled at each half-state point of the command states until the command fires.
- **Ready.** Once the command is on, ready is sampled at each state boundary. Every boundary without ready adds another command state.

Neither input moves the latch strobe, the enable or the direction.

Top module: `busSeqTop`

## Requirements
- R1: While `rstN` is low, and after its release until a cycle starts, `ale`, `rdCmd`, `wrCmd` and `den` are 0, `dirTx` is 0 (receive) and `phase2` is 0.
- R2: `phase2` starts at 0 after reset and toggles on every clock, so that each bus state lasts exactly two clocks.
- R3: `cycStart` and `cycWrite` are sampled at the end of phase 2 of an idle state, or of the last command state. When `cycStart` is 1, `ale` is 1 for exactly the two clocks of the status state that follows and is 0 at all other times.
- R4: `dirTx` takes the latched `cycWrite` value (1 = transmit, 0 = receive) at the end of phase 1 of the status state. It holds that value until the same point of a later cycle.
- R5: On a write cycle, `den` rises at the start of the first command state. On a read cycle, it rises at the start of phase 2 of the first command state. It falls when the cycle ends, is never 1 during a status state, and its edges do not depend on `cmdHold`.
- R6: In a command state, `cmdHold` is sampled at the end of phase 1 until the command fires. A sample of 0 raises `wrCmd` on a write cycle or `rdCmd` on a read cycle. The other strobe stays 0, and both never rise at any other point.
- R7: Once the command strobe is on, `cmdHold` is ignored for the rest of the cycle.
- R8: `rdy` is sampled at the end of phase 2 of a command state, and only once the command is on. A 1 is ignored before the command fires. The first ready sample ends the cycle, which drops the command strobe and `den`; a 0 adds another command state.
- R9: If `cycStart` is 1 at the end of the last command state, the next clock enters a new status state directly, with no idle state in between.
- R10: `dirTx` only changes while `den` is 0, and `den` was also 0 on the clock before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two clocks make one bus state |
| rstN | input | 1 | Active-low synchronous reset |
| cycStart | input | 1 | Request to begin a bus cycle |
| cycWrite | input | 1 | Cycle type: 1 = write, 0 = read |
| cmdHold | input | 1 | Command delay: 1 keeps the command strobe off |
| rdy | input | 1 | Ready: 1 ends the cycle once the command is on |
| phase2 | output | 1 | High during the second half of each bus state |
| ale | output | 1 | Address latch enable, high for the status state |
| rdCmd | output | 1 | Read command strobe |
| wrCmd | output | 1 | Write command strobe |
| den | output | 1 | Data transceiver enable |
| dirTx | output | 1 | Transceiver direction: 1 = transmit, 0 = receive |

## Verification
The bench raises `rdy` while the command is still held back. A design that samples ready too early would end the cycle with no command, or with one only half a state long.

It raises `cmdHold` again after the command has fired. A design that keeps sampling it would drop the strobe in the middle of the cycle.

Delayed and undelayed cycles are checked against the same fixed points for `ale` and `den`. A design that ties the enable timing to the command would show `den` late on delayed reads.

Back-to-back cycles that switch between write and read show two faults:
- a direction change made while the enable is still on (bus contention);
- a lost start request at the last command state.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STATUS = 2'd1,
    ST_CMD    = 2'd2
  } busState_t;

  typedef struct packed {
    logic startCycle;
    logic enterCmd;
    logic dirSample;
    logic midFirstCmd;
    logic fireCmd;
    logic endCycle;
  } seqStrobe_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycStart,
  input  logic       cmdHold,
  input  logic       rdy,
  output logic       phase2,
  output seqStrobe_t stb
);

  busState_t state, stateNext;
  logic      ph;
  logic      cmdOn;
  logic      firstCmd;
  logic      stateEnd;
  logic      halfPoint;
  logic      finishing;

  assign stateEnd  = ph;
  assign halfPoint = !ph;
  assign phase2    = ph;

  // a cycle finishes at a state boundary once the command is on and ready is seen
  assign finishing = (state == ST_CMD) && stateEnd && cmdOn && rdy;

  always_comb begin
    stb             = '0;
    stb.startCycle  = stateEnd && cycStart && ((state == ST_IDLE) || finishing);
    stb.endCycle    = finishing;
    stb.enterCmd    = (state == ST_STATUS) && stateEnd;
    stb.dirSample   = (state == ST_STATUS) && halfPoint;
    stb.midFirstCmd = (state == ST_CMD) && firstCmd && halfPoint;
    stb.fireCmd     = (state == ST_CMD) && halfPoint && !cmdOn && !cmdHold;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (stb.startCycle) stateNext = ST_STATUS;
      ST_STATUS: if (stb.enterCmd) stateNext = ST_CMD;
      ST_CMD: begin
        if (finishing) stateNext = cycStart ? ST_STATUS : ST_IDLE;
      end
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ph       <= 1'b0;
      cmdOn    <= 1'b0;
      firstCmd <= 1'b0;
    end else begin
      state <= stateNext;
      ph    <= !ph;
      if (stb.enterCmd || stb.endCycle) cmdOn <= 1'b0;
      else if (stb.fireCmd)             cmdOn <= 1'b1;
      if (stb.enterCmd)                 firstCmd <= 1'b1;
      else if (stateEnd)                firstCmd <= 1'b0;
    end
  end

endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycWrite,
  input  seqStrobe_t stb,
  output logic       ale,
  output logic       rdCmd,
  output logic       wrCmd,
  output logic       den,
  output logic       dirTx
);

  logic isWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isWrite <= 1'b0;
      ale     <= 1'b0;
      rdCmd   <= 1'b0;
      wrCmd   <= 1'b0;
      den     <= 1'b0;
      dirTx   <= 1'b0;
    end else begin
      if (stb.startCycle) isWrite <= cycWrite;

      if (stb.startCycle)    ale <= 1'b1;
      else if (stb.enterCmd) ale <= 1'b0;

      // direction moves mid-status, a full clock after any enable has dropped
      if (stb.dirSample) dirTx <= isWrite;

      if (stb.endCycle)                        den <= 1'b0;
      else if (stb.enterCmd && isWrite)        den <= 1'b1;
      else if (stb.midFirstCmd && !isWrite)    den <= 1'b1;

      if (stb.endCycle) begin
        rdCmd <= 1'b0;
        wrCmd <= 1'b0;
      end else if (stb.fireCmd) begin
        rdCmd <= !isWrite;
        wrCmd <= isWrite;
      end
    end
  end

endmodule

// File: rtl/busSeqTop.sv
module busSeqTop
  import busSeqPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cycStart,
  input  logic cycWrite,
  input  logic cmdHold,
  input  logic rdy,
  output logic phase2,
  output logic ale,
  output logic rdCmd,
  output logic wrCmd,
  output logic den,
  output logic dirTx
);

  seqStrobe_t stb;

  busSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cycStart (cycStart),
    .cmdHold  (cmdHold),
    .rdy      (rdy),
    .phase2   (phase2),
    .stb      (stb)
  );

  busSeqDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cycWrite (cycWrite),
    .stb      (stb),
    .ale      (ale),
    .rdCmd    (rdCmd),
    .wrCmd    (wrCmd),
    .den      (den),
    .dirTx    (dirTx)
  );

endmodule

// File: rtl/busSeqChecker.sv
module busSeqChecker (
  input logic clk,
  input logic rstN,
  input logic phase2,
  input logic ale,
  input logic rdCmd,
  input logic wrCmd,
  input logic den,
  input logic dirTx
);

  logic pastOk;

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    phase2 != $past(phase2)); // R2

  AST_ALE_TWO_CLK: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    $rose(ale) |-> !phase2 ##1 ale); // R3

  AST_ALE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> !rdCmd && !wrCmd && !den); // R5

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !(rdCmd && wrCmd)); // R6

  AST_CMD_RISE_PHASE: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    $rose(rdCmd || wrCmd) |-> phase2); // R6

  AST_DEN_FALL_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    $fell(den) |-> !phase2 && !rdCmd && !wrCmd); // R8

  AST_DIR_QUIET: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    (dirTx != $past(dirTx)) |-> !den && !$past(den)); // R10

  AST_DIR_IN_STATUS: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    (dirTx != $past(dirTx)) |-> ale && phase2); // R4

endmodule

bind busSeqTop busSeqChecker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .phase2 (phase2),
  .ale    (ale),
  .rdCmd  (rdCmd),
  .wrCmd  (wrCmd),
  .den    (den),
  .dirTx  (dirTx)
);

// File: tb/busSeqTop_tb.sv
module busSeqTop_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycStart = 1'b0;
  logic cycWrite = 1'b0;
  logic cmdHold = 1'b0;
  logic rdy = 1'b0;
  logic phase2, ale, rdCmd, wrCmd, den, dirTx;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;
  logic expDir = 1'b0;

  always #5 clk = ~clk;

  busSeqTop u_dut (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .cycWrite(cycWrite),
    .cmdHold(cmdHold), .rdy(rdy), .phase2(phase2), .ale(ale),
    .rdCmd(rdCmd), .wrCmd(wrCmd), .den(den), .dirTx(dirTx)
  );

  task automatic cmp(input string what, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic checkQuiet(input string what);
    cmp({what, " ale"}, ale, 1'b0);
    cmp({what, " rdCmd"}, rdCmd, 1'b0);
    cmp({what, " wrCmd"}, wrCmd, 1'b0);
    cmp({what, " den"}, den, 1'b0);
  endtask

  // Entry: at a phase-2 negedge with cycStart/cycWrite already driven.
  // Exit: at a phase-2 negedge, either idle or with the next start driven.
  task automatic busCycle(input bit wr, input int hold, input int waits,
                          input bit chain, input bit nextWr);
    int nTc = hold + waits + 1;
    @(posedge clk);
    @(negedge clk);                       // status state, phase 1
    cycStart = 1'b0;
    cmdHold  = 1'b0;                      // not sampled in status: R6
    rdy      = 1'b1;                      // not sampled in status: R8
    cmp("R3 ale high in status ph1", ale, 1'b1);
    cmp("R4 dir unchanged before status midpoint", dirTx, expDir);
    cmp("R5 den low in status", den, 1'b0);
    cmp("R9 no command carried into status", rdCmd | wrCmd, 1'b0);
    @(negedge clk);                       // status state, phase 2
    expDir = wr;
    cmp("R3 ale high in status ph2", ale, 1'b1);
    cmp("R4 dir follows cycle type", dirTx, wr);
    cmp("R5 den low in status ph2", den, 1'b0);
    for (int t = 0; t < nTc; t++) begin
      @(negedge clk);                     // command state, phase 1
      cmp("R3 ale low in command state", ale, 1'b0);
      cmp("R5 den timing ph1", den, wr || (t > 0));
      cmp("R6 rdCmd ph1", rdCmd, !wr && (t > hold));
      cmp("R6 wrCmd ph1", wrCmd, wr && (t > hold));
      cmdHold = (t != hold);              // high again after firing: R7
      rdy = (t < hold) ? 1'b1 : ((t - hold) >= waits);
      @(negedge clk);                     // command state, phase 2
      cmp("R5 den on ph2", den, 1'b1);
      cmp("R6 rdCmd ph2", rdCmd, !wr && (t >= hold));
      cmp("R7 wrCmd kept", wrCmd, wr && (t >= hold));
      cmp("R8 command persists until ready", rdCmd | wrCmd, t >= hold);
      cmp("R10 dir stable in command state", dirTx, wr);
      if (t == nTc - 1) begin
        cycStart = chain;
        cycWrite = nextWr;
      end
    end
    if (!chain) begin
      @(negedge clk);                     // idle, phase 1
      cycStart = 1'b0;
      rdy = 1'b0;
      cmdHold = 1'b0;
      checkQuiet("R8 cycle ended");
      cmp("R4 dir held in idle", dirTx, expDir);
      @(negedge clk);
      checkQuiet("R3 idle ph2");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checkQuiet("R1 in reset");
    cmp("R1 dir in reset", dirTx, 1'b0);
    cmp("R1 phase in reset", phase2, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    cmp("R2 phase first after reset", phase2, 1'b1);
    @(negedge clk);
    cmp("R2 phase toggles", phase2, 1'b0);
    @(negedge clk);
    cmp("R2 phase toggles again", phase2, 1'b1);
    // idle with no request, even with hold/ready moving
    for (int i = 0; i < 4; i++) begin
      cmdHold = i[0];
      rdy = !i[0];
      @(negedge clk);
      checkQuiet("R1 idle without start");
      cmp("R1 dir idle", dirTx, 1'b0);
    end
    // now at a phase-2 negedge
    cmp("R2 alignment", phase2, 1'b1);

    cycStart = 1'b1; cycWrite = 1'b0;
    busCycle(1'b0, 0, 0, 1'b0, 1'b0);     // plain read
    cycStart = 1'b1; cycWrite = 1'b1;
    busCycle(1'b1, 0, 0, 1'b0, 1'b0);     // plain write
    cycStart = 1'b1; cycWrite = 1'b0;
    busCycle(1'b0, 2, 1, 1'b0, 1'b0);     // delayed read with a wait state
    cycStart = 1'b1; cycWrite = 1'b1;
    busCycle(1'b1, 3, 0, 1'b0, 1'b0);     // long-delayed write
    cycStart = 1'b1; cycWrite = 1'b1;
    busCycle(1'b1, 0, 2, 1'b1, 1'b0);     // R9: write chained into read
    busCycle(1'b0, 1, 0, 1'b1, 1'b0);     // read chained into read
    busCycle(1'b0, 0, 3, 1'b1, 1'b1);     // read chained into write
    busCycle(1'b1, 1, 1, 1'b0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule